// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block is a host-side engine that writes a contiguous range of bytes into a flash part through the part's command interface. The part takes a command byte on a write strobe, can be told to program one byte, and can then be put into a margin-read mode where a read returns what the cell now holds. The sequencer fetches each byte from a data source. It sends the program-setup command, then the byte to its address. It waits out the program time, sends the verify command, waits again, and reads the byte back. If the read matches, it moves to the next address. If it does not, it pulses the same byte again, up to a fixed budget of attempts.

A run begins with a one-cycle `start` that carries the first and last address of the range. The sequencer raises the programming-supply enable and waits for the supply to settle before the first bus access. At the end, whether the run passed or failed, it writes the read-mode command, drops the supply enable and waits for the supply to fall. Only after that does it give a single `done` pulse. The pulse carries a pass flag and the address where the run stopped.

All wait times are parameters counted in clock cycles. At a 125 MHz clock the defaults give about 10 µs of program time, 6 µs of verify settle and 8 µs of supply ramp.

Top module: `pgm_verify_seq`

## Requirements
- R1: After reset and between runs, `bus_wr`, `bus_rd`, `vpp_en` and `done` are low.
- R2: On `start` in idle, `vpp_en` rises in the next cycle and stays high for RAMP_CYC cycles with no bus strobe before the first bus write. It also stays high through every bus access of the run.
- R3: Each attempt on address A is this exact cycle stream, all at address A: a write of 40h; a write of the data byte; PROG_CYC cycles without strobes; a write of C0h; VERIFY_CYC cycles without strobes (none when VERIFY_CYC is 0); one read cycle. `bus_wr` and `bus_rd` are never high together.
- R4: A read that equals the programmed byte, on an address other than the last, starts the next attempt at address A+1 in the following cycle, with a fresh pulse budget.
- R5: A read that differs from the programmed byte, with budget left, starts a new attempt on the same address in the following cycle.
- R6: If the read on the MAX_PULSES-th attempt of one address still differs, the run ends as a failure. `fail_addr` reports that address.
- R7: Every run ends with a write of 00h at the stopping address, still with `vpp_en` high. Then come RAMP_CYC cycles with `vpp_en` low, then the `done` cycle.
- R8: `done` is high for exactly one cycle per run. In that cycle `pass` is 1 for a passed run and 0 for a failed one, and `fail_addr` holds the stopping address (the last address on a pass).
- R9: `start` while a run is in progress, including in its `done` cycle, has no effect on the bus stream or the outcome.
- R10: A range whose first and last address are equal programs exactly that one byte.
- R11: `src_addr` gives the address being worked on. The data byte written in an attempt is `src_data` for that address, and the compare uses that same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle run request, accepted only when idle |
| first_addr | input | AW | First address of the range, sampled with `start` |
| last_addr | input | AW | Last address of the range, sampled with `start` |
| src_addr | output | AW | Address whose data byte is requested from the source |
| src_data | input | DW | Data byte for `src_addr` |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | DW | Flash bus write data (command or data byte) |
| bus_rdata | input | DW | Flash bus read data, sampled in the `bus_rd` cycle |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_rd | output | 1 | Single-cycle read strobe |
| vpp_en | output | 1 | Programming-supply enable |
| done | output | 1 | End-of-run pulse |
| pass | output | 1 | Run result, valid with `done` |
| fail_addr | output | AW | Stopping address, valid with `done` |

## Verification
Several decisions can fall on the same verify read. A match, the last address of the range and the end of the pulse budget can all be true in one cycle. The bench provokes this with a byte that the flash model accepts only on exactly the MAX_PULSES-th pulse, including one in a single-byte range. There the match must win, so the run passes and no failure is reported. A byte that needs one pulse more must fail on that same address. A `start` pulse dropped into the middle of a run, and another into the `done` cycle, is judged against a per-cycle expected stream built up front from the requirements. Any change in strobes, addresses or outcome is reported.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RAMP_UP,
      ST_SETUP,
      ST_PROG,
      ST_PWAIT,
      ST_VCMD,
      ST_VWAIT,
      ST_READ,
      ST_RSTCMD,
      ST_RAMP_DN,
      ST_DONE
   } pvs_state_e;

   function automatic int unsigned pvs_max3(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pvs_wait_timer.sv
module pvs_wait_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pvs_addr_walk.sv
module pvs_addr_walk #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] first,
   input  logic [AW-1:0] last,
   input  logic          step,
   output logic [AW-1:0] cur,
   output logic          at_last
);

   logic [AW-1:0] cur_q;
   logic [AW-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         last_q <= '0;
      end else if (load) begin
         cur_q  <= first;
         last_q <= last;
      end else if (step) begin
         cur_q  <= cur_q + 1'b1;
      end
   end

   assign cur     = cur_q;
   assign at_last = (cur_q == last_q);

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur == $past(cur) + 1'b1));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cur));

endmodule

// File: rtl/pvs_pulse_ctr.sv
module pvs_pulse_ctr #(
   parameter int MAX_PULSES = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic final_try
);

   localparam int PW = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;
   localparam logic [PW-1:0] LAST_IDX = PW'(MAX_PULSES - 1);

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (bump)   cnt_q <= cnt_q + 1'b1;
   end

   assign final_try = (cnt_q == LAST_IDX);

   assert_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= LAST_IDX));

   assert_no_bump_past_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !clear) |-> !final_try);

endmodule

// File: rtl/pgm_verify_seq.sv
module pgm_verify_seq
   import pvs_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int PROG_CYC   = 1250,
   parameter int VERIFY_CYC = 750,
   parameter int RAMP_CYC   = 1000,
   parameter int MAX_PULSES = 25,
   parameter logic [DW-1:0] CMD_SETUP  = DW'(8'h40),
   parameter logic [DW-1:0] CMD_VERIFY = DW'(8'hC0),
   parameter logic [DW-1:0] CMD_READ   = DW'(8'h00)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] first_addr,
   input  logic [AW-1:0] last_addr,
   output logic [AW-1:0] src_addr,
   input  logic [DW-1:0] src_data,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          bus_wr,
   output logic          bus_rd,
   output logic          vpp_en,
   output logic          done,
   output logic          pass,
   output logic [AW-1:0] fail_addr
);

   localparam int unsigned WMAX = pvs_max3(PROG_CYC, VERIFY_CYC, RAMP_CYC);
   localparam int TW = $clog2(WMAX + 1);
   localparam logic [TW-1:0] LD_PROG = TW'(PROG_CYC - 1);
   localparam logic [TW-1:0] LD_RAMP = TW'(RAMP_CYC - 1);
   localparam logic [TW-1:0] LD_VER  = TW'((VERIFY_CYC > 0) ? VERIFY_CYC - 1 : 0);

   // elaboration-time parameter checks
   generate
      if (AW < 1)          begin : g_bad_aw   $error("AW must be at least 1");          end
      if (DW < 8)          begin : g_bad_dw   $error("DW must hold an 8-bit command");  end
      if (PROG_CYC < 1)    begin : g_bad_prog $error("PROG_CYC must be at least 1");    end
      if (RAMP_CYC < 1)    begin : g_bad_ramp $error("RAMP_CYC must be at least 1");    end
      if (VERIFY_CYC < 0)  begin : g_bad_ver  $error("VERIFY_CYC must not be negative"); end
      if (MAX_PULSES < 1)  begin : g_bad_max  $error("MAX_PULSES must be at least 1");  end
   endgenerate

   // variant: a zero verify settle time removes the wait stage
   logic vwait_en;
   generate
      if (VERIFY_CYC > 0) begin : g_vwait
         assign vwait_en = 1'b1;
      end else begin : g_no_vwait
         assign vwait_en = 1'b0;
      end
   endgenerate

   pvs_state_e    state_q, state_d;
   logic [DW-1:0] data_q;
   logic          pass_q, pass_d;

   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_expired;
   logic          addr_load, addr_step, at_last;
   logic [AW-1:0] cur_addr;
   logic          ctr_clear, ctr_bump, final_try;
   logic          match;

   pvs_wait_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   pvs_addr_walk #(.AW(AW)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (addr_load),
      .first   (first_addr),
      .last    (last_addr),
      .step    (addr_step),
      .cur     (cur_addr),
      .at_last (at_last)
   );

   pvs_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (ctr_clear),
      .bump      (ctr_bump),
      .final_try (final_try)
   );

   assign match = (bus_rdata == data_q);

   always_comb begin
      state_d   = state_q;
      pass_d    = pass_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      addr_load = 1'b0;
      addr_step = 1'b0;
      ctr_clear = 1'b0;
      ctr_bump  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d   = ST_RAMP_UP;
               tmr_load  = 1'b1;
               tmr_val   = LD_RAMP;
               addr_load = 1'b1;
               ctr_clear = 1'b1;
               pass_d    = 1'b0;
            end
         end
         ST_RAMP_UP: if (tmr_expired) state_d = ST_SETUP;
         ST_SETUP:   state_d = ST_PROG;
         ST_PROG: begin
            state_d  = ST_PWAIT;
            tmr_load = 1'b1;
            tmr_val  = LD_PROG;
         end
         ST_PWAIT:   if (tmr_expired) state_d = ST_VCMD;
         ST_VCMD: begin
            if (vwait_en) begin
               state_d  = ST_VWAIT;
               tmr_load = 1'b1;
               tmr_val  = LD_VER;
            end else begin
               state_d  = ST_READ;
            end
         end
         ST_VWAIT:   if (tmr_expired) state_d = ST_READ;
         ST_READ: begin
            if (match) begin
               ctr_clear = 1'b1;
               if (at_last) begin
                  pass_d  = 1'b1;
                  state_d = ST_RSTCMD;
               end else begin
                  addr_step = 1'b1;
                  state_d   = ST_SETUP;
               end
            end else if (final_try) begin
               pass_d  = 1'b0;
               state_d = ST_RSTCMD;
            end else begin
               ctr_bump = 1'b1;
               state_d  = ST_SETUP;
            end
         end
         ST_RSTCMD: begin
            state_d  = ST_RAMP_DN;
            tmr_load = 1'b1;
            tmr_val  = LD_RAMP;
         end
         ST_RAMP_DN: if (tmr_expired) state_d = ST_DONE;
         ST_DONE:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         pass_q  <= pass_d;
         if (state_q == ST_PROG) data_q <= src_data;
      end
   end

   always_comb begin
      bus_wr    = 1'b0;
      bus_wdata = '0;
      unique case (state_q)
         ST_SETUP:  begin bus_wr = 1'b1; bus_wdata = CMD_SETUP;  end
         ST_PROG:   begin bus_wr = 1'b1; bus_wdata = src_data;   end
         ST_VCMD:   begin bus_wr = 1'b1; bus_wdata = CMD_VERIFY; end
         ST_RSTCMD: begin bus_wr = 1'b1; bus_wdata = CMD_READ;   end
         default:   ;
      endcase
   end

   assign bus_rd    = (state_q == ST_READ);
   assign vpp_en    = !(state_q inside {ST_IDLE, ST_RAMP_DN, ST_DONE});
   assign done      = (state_q == ST_DONE);
   assign pass      = done & pass_q;
   assign bus_addr  = cur_addr;
   assign src_addr  = cur_addr;
   assign fail_addr = cur_addr;

   assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   assert_supply_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr || bus_rd) |-> vpp_en);

   assert_done_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_ramp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !$past(vpp_en));

   assert_stop_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RAMP_DN) |=> $stable(fail_addr));

   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != ST_IDLE) |=> (state_q != ST_RAMP_UP));

endmodule

// File: tb/sim_pgm_verify_seq.sv
module sim_pgm_verify_seq;

   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int PC  = 4;
   localparam int VC  = 2;
   localparam int RC  = 3;
   localparam int MX  = 4;

   typedef struct {
      bit          wr, rd, vpp, dn, ps;
      logic [15:0] a;
      logic [7:0]  d;
      string       tag;
   } ev_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] first_addr = '0, last_addr = '0;
   logic [AW-1:0] src_addr, bus_addr, fail_addr;
   logic [DW-1:0] src_data, bus_wdata, bus_rdata;
   logic          bus_wr, bus_rd, vpp_en, done, pass;

   int   checks = 0;
   int   errors = 0;
   ev_t  q[$];

   logic [7:0] fmem [64];
   int         fpulses [64];
   int         need [64];
   bit         armed = 1'b0;

   always #4 clk = ~clk;

   pgm_verify_seq #(
      .AW(AW), .DW(DW), .PROG_CYC(PC), .VERIFY_CYC(VC),
      .RAMP_CYC(RC), .MAX_PULSES(MX)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .first_addr(first_addr), .last_addr(last_addr),
      .src_addr(src_addr), .src_data(src_data),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .vpp_en(vpp_en),
      .done(done), .pass(pass), .fail_addr(fail_addr)
   );

   function automatic logic [7:0] srcf(input logic [15:0] a);
      logic [7:0] v;
      v = 8'((a * 37 + 5) & 16'hFF);
      return (v == 8'hFF) ? 8'h5A : v;
   endfunction

   assign src_data  = srcf(src_addr);
   assign bus_rdata = fmem[bus_addr[5:0]];

   // flash model: a byte takes its value only after need[] program pulses
   always @(posedge clk) begin
      if (rst_n && bus_wr) begin
         if (armed) begin
            armed = 1'b0;
            fpulses[bus_addr[5:0]] = fpulses[bus_addr[5:0]] + 1;
            if (fpulses[bus_addr[5:0]] >= need[bus_addr[5:0]])
               fmem[bus_addr[5:0]] = bus_wdata;
         end else begin
            armed = (bus_wdata == 8'h40);
         end
      end
   end

   task automatic push(input bit wr, input bit rd, input bit vpp, input bit dn,
                       input bit ps, input logic [15:0] a, input logic [7:0] d,
                       input string tag);
      ev_t e;
      e.wr = wr; e.rd = rd; e.vpp = vpp; e.dn = dn; e.ps = ps;
      e.a = a; e.d = d; e.tag = tag;
      q.push_back(e);
   endtask

   // expected cycle stream of one run, built from the requirements
   task automatic plan_run(input int first, input int last);
      int a;
      bit ok;
      int n;
      for (int i = 0; i < RC; i++) push(0, 0, 1, 0, 0, 0, 0, "R2");
      ok = 1'b1;
      a  = first;
      forever begin
         n = (need[a] <= MX) ? need[a] : MX;
         for (int k = 0; k < n; k++) begin
            push(1, 0, 1, 0, 0, 16'(a), 8'h40, "R3");
            push(1, 0, 1, 0, 0, 16'(a), srcf(16'(a)), "R11");
            for (int i = 0; i < PC; i++) push(0, 0, 1, 0, 0, 0, 0, "R3");
            push(1, 0, 1, 0, 0, 16'(a), 8'hC0, "R3");
            for (int i = 0; i < VC; i++) push(0, 0, 1, 0, 0, 0, 0, "R3");
            push(0, 1, 1, 0, 0, 16'(a), 0, (k == 0) ? "R4" : "R5");
         end
         if (need[a] > MX) begin ok = 1'b0; break; end
         if (a == last) break;
         a++;
      end
      push(1, 0, 1, 0, 0, 16'(a), 8'h00, "R7");
      for (int i = 0; i < RC; i++) push(0, 0, 0, 0, 0, 0, 0, "R7");
      push(0, 0, 0, 1, ok, 16'(a), 0, ok ? "R8" : "R6");
   endtask

   // per-cycle comparison, sampled mid-high
   initial begin
      forever begin
         @(posedge clk);
         #2;
         begin
            ev_t e;
            bit  bad;
            if (q.size() > 0) e = q.pop_front();
            else begin
               e.wr = 0; e.rd = 0; e.vpp = 0; e.dn = 0; e.ps = 0;
               e.a = 0; e.d = 0; e.tag = "R1";
            end
            bad = (bus_wr !== e.wr) || (bus_rd !== e.rd) ||
                  (vpp_en !== e.vpp) || (done !== e.dn);
            if (e.wr && ((bus_addr !== e.a) || (bus_wdata !== e.d))) bad = 1'b1;
            if (e.rd && (bus_addr !== e.a)) bad = 1'b1;
            if (e.dn && ((pass !== e.ps) || (fail_addr !== e.a))) bad = 1'b1;
            checks++;
            if (bad) begin
               errors++;
               $display("FAIL %s t=%0t actual wr=%b rd=%b vpp=%b done=%b pass=%b addr=%h wd=%h fa=%h expected wr=%b rd=%b vpp=%b done=%b pass=%b addr=%h wd=%h",
                        e.tag, $time, bus_wr, bus_rd, vpp_en, done, pass, bus_addr,
                        bus_wdata, fail_addr, e.wr, e.rd, e.vpp, e.dn, e.ps, e.a, e.d);
            end
         end
      end
   end

   task automatic clear_flash();
      for (int i = 0; i < 64; i++) begin
         fmem[i] = 8'hFF; fpulses[i] = 0; need[i] = 1;
      end
      armed = 1'b0;
   endtask

   task automatic launch(input int first, input int last);
      @(negedge clk);
      first_addr = 16'(first);
      last_addr  = 16'(last);
      start      = 1'b1;
      plan_run(first, last);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_run();
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_mem(input int first, input int last, input string tag);
      for (int a = first; a <= last; a++) begin
         checks++;
         if (fmem[a] !== srcf(16'(a))) begin
            errors++;
            $display("FAIL %s mem[%0d] actual %h expected %h", tag, a, fmem[a], srcf(16'(a)));
         end
      end
   endtask

   task automatic main_seq();
      clear_flash();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 R11: plain range, every byte takes on the first pulse
      launch(0, 7);
      finish_run();
      check_mem(0, 7, "R11");

      // R5: retries on several bytes
      clear_flash();
      need[8] = 2; need[9] = 3; need[11] = 2;
      launch(8, 11);
      finish_run();
      check_mem(8, 11, "R5");

      // R10 with budget boundary: single byte accepted on the last allowed pulse
      clear_flash();
      need[20] = MX;
      launch(20, 20);
      finish_run();
      check_mem(20, 20, "R10");

      // R6: one byte needs one pulse more than the budget
      clear_flash();
      need[26] = MX + 1;
      launch(24, 28);
      finish_run();
      check_mem(24, 25, "R6");

      // R9: start pulses mid-run and in the done cycle are ignored
      clear_flash();
      need[31] = 2;
      launch(30, 31);
      repeat (10) @(negedge clk);
      first_addr = 16'd40; last_addr = 16'd41; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (q.size() > 1) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_run();
      check_mem(30, 31, "R9");
   endtask

   initial begin
      bit wd;
      wd = 1'b0;
      fork
         main_seq();
         begin
            repeat (150000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      if (wd) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule